// File: doc/BRIEF.md
# Idle-Gated Line Configuration Shadow

This block sits between a host register port and a serial transmitter. It keeps a shadow copy of the transmitter's line settings:

- an operating-mode byte, which also holds the flow-control bits;
- a modem output pin byte;
- a character format byte;
- a 10-bit baud divisor.

The host may write the shadows at any moment. The live copies that drive the transmitter are loaded only while the transmitter reports that it is idle. A change therefore never lands in the middle of a character, where it could garble the line.

Every write to a deferred field raises one common pending flag. On the first clock edge where the flag is set and the idle input is high, all four shadows move to the live registers together, and the flag drops. If the transmitter is already idle, this happens on the edge right after the write.

The divisor is spread over two live bytes. Its low eight bits form one byte. Its top two bits form bits 7:6 of a clock-control byte. The low six bits of the clock-control byte are an auxiliary field that the host writes directly; a commit leaves them untouched. The break-send control is a bit of the format byte, so starting or ending a break is also deferred. A read port returns the shadow values, so the host sees what it wrote before the commit has happened.

Top module: `cfg_shadow_commit`

## Requirements
- R1: After reset, the outputs show the default values: live_mode 8'h0C, live_port 8'h16, live_fmt 8'h03, divisor 10'd23, and auxiliary field 6'h38. No commit is pending, so idle cycles leave these values unchanged.
- R2: The deferred addresses are mode (0), port (1), format (2), divisor low byte (3) and divisor high bits (4, taking wr_data[1:0]). A write to one of these updates only the shadow and sets the pending flag. The live outputs do not change while tx_idle is low.
- R3: When the pending flag is set and tx_idle is high at a clock edge, that edge commits the shadows and clears the flag. A write made while tx_idle is already high reaches the live outputs one edge after the write's own edge.
- R4: A commit loads the mode, port, format and divisor shadows into the live registers on the same edge.
- R5: On commit, divisor bits 7:0 go to live_div_lo and divisor bits 9:8 go to live_clk_ctl[7:6]. live_clk_ctl[5:0] is unchanged by a commit.
- R6: A write to address 5 loads wr_data[5:0] into live_clk_ctl[5:0] on its own edge, whatever tx_idle is. It does not set the pending flag.
- R7: tx_break follows bit 6 of the committed format byte. It changes only on a commit.
- R8: A deferred write in the same cycle as a commit is kept. The commit copies the shadow values from before that write, the flag stays set, and the new value is committed on a later idle edge.
- R9: rd_data shows the shadow byte for addresses 0 to 3. It shows {6'b0, divisor[9:8]} for address 4, live_clk_ctl for address 5, and 0 for addresses 6 and 7. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Read-back address |
| rd_data | output | 8 | Read-back data (shadow view) |
| tx_idle | input | 1 | High while the transmitter is idle |
| live_mode | output | 8 | Live mode and flow-control byte |
| live_port | output | 8 | Live modem output byte |
| live_fmt | output | 8 | Live character format byte |
| live_div_lo | output | 8 | Live divisor bits 7:0 |
| live_clk_ctl | output | 8 | Divisor bits 9:8 in bits 7:6, auxiliary field in bits 5:0 |
| tx_break | output | 1 | Break-send control from the live format byte |

## Verification
The hardest case to reach from the ports is a deferred write that lands on the very edge where an earlier pending commit fires. It needs the flag already set, tx_idle rising, and a strobe, all in one cycle. The stimulus first writes with tx_idle low to arm the flag. It then raises tx_idle and issues a second write to the same field in one cycle. It checks that the first value is committed and the second follows one edge later. Long random stretches of writes mixed with a toggling idle line then hit this case many more times. A behavioural model checks each of those cases on every clock.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 10;
  localparam int AUX_W  = 6;
  localparam int BRK_BIT = 6;

  localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PORT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_FMT    = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_AUX    = 3'd5;

  typedef struct packed {
    logic [DATA_W-1:0] mode;
    logic [DATA_W-1:0] port;
    logic [DATA_W-1:0] fmt;
    logic [DIV_W-1:0]  div;
  } cfg_set_t;

  // low live byte of the divisor
  function automatic logic [DATA_W-1:0] div_low(input logic [DIV_W-1:0] d);
    return d[DATA_W-1:0];
  endfunction

  // clock-control byte: divisor top bits above the auxiliary field
  function automatic logic [DATA_W-1:0] clk_ctl_merge(input logic [DIV_W-1:0] d,
                                                       input logic [AUX_W-1:0] aux);
    return {d[DIV_W-1:DATA_W], aux};
  endfunction

  // true for addresses that go through the deferred commit
  function automatic logic is_deferred(input logic [ADDR_W-1:0] a);
    return (a == A_MODE) || (a == A_PORT) || (a == A_FMT) ||
           (a == A_DIV_LO) || (a == A_DIV_HI);
  endfunction
endpackage

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import cfgc_pkg::*;
#(
  parameter cfg_set_t INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_set_t          shadow,
  output logic              cfg_wr
);
  assign cfg_wr = wr_en && is_deferred(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= INIT;
    end else if (cfg_wr) begin
      case (wr_addr)
        A_MODE:   shadow.mode <= wr_data;
        A_PORT:   shadow.port <= wr_data;
        A_FMT:    shadow.fmt  <= wr_data;
        A_DIV_LO: shadow.div[DATA_W-1:0] <= wr_data;
        default:  shadow.div[DIV_W-1:DATA_W] <= wr_data[DIV_W-DATA_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic tx_idle,
  output logic pending,
  output logic commit
);
  // commit fires on the edge where a pending change meets an idle line
  assign commit = pending && tx_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= cfg_wr || (pending && !commit);
  end
endmodule

// File: rtl/cfg_live_bank.sv
module cfg_live_bank
  import cfgc_pkg::*;
#(
  parameter cfg_set_t         INIT     = '0,
  parameter logic [AUX_W-1:0] AUX_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  cfg_set_t         shadow,
  input  logic             aux_wr,
  input  logic [AUX_W-1:0] aux_data,
  output cfg_set_t         live,
  output logic [AUX_W-1:0] aux
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      live <= INIT;
    else if (commit) live <= shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      aux <= AUX_INIT;
    else if (aux_wr) aux <= aux_data;
  end
endmodule

// File: rtl/cfg_shadow_commit.sv
module cfg_shadow_commit
  import cfgc_pkg::*;
#(
  parameter logic [DATA_W-1:0] MODE_INIT = 8'h0C,
  parameter logic [DATA_W-1:0] PORT_INIT = 8'h16,
  parameter logic [DATA_W-1:0] FMT_INIT  = 8'h03,
  parameter logic [DIV_W-1:0]  DIV_INIT  = 10'd23,
  parameter logic [AUX_W-1:0]  AUX_INIT  = 6'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tx_idle,
  output logic [DATA_W-1:0] live_mode,
  output logic [DATA_W-1:0] live_port,
  output logic [DATA_W-1:0] live_fmt,
  output logic [DATA_W-1:0] live_div_lo,
  output logic [DATA_W-1:0] live_clk_ctl,
  output logic              tx_break
);
  localparam cfg_set_t INIT_SET = '{mode: MODE_INIT, port: PORT_INIT,
                                    fmt: FMT_INIT, div: DIV_INIT};

  cfg_set_t         shadow;
  cfg_set_t         live;
  logic [AUX_W-1:0] aux;
  logic             cfg_wr;
  logic             aux_wr;
  logic             pending;
  logic             commit;

  assign aux_wr = wr_en && (wr_addr == A_AUX);

  cfg_shadow_bank #(.INIT(INIT_SET)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .shadow(shadow), .cfg_wr(cfg_wr)
  );

  cfg_commit_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .tx_idle(tx_idle),
    .pending(pending), .commit(commit)
  );

  cfg_live_bank #(.INIT(INIT_SET), .AUX_INIT(AUX_INIT)) u_live (
    .clk(clk), .rst_n(rst_n), .commit(commit), .shadow(shadow),
    .aux_wr(aux_wr), .aux_data(wr_data[AUX_W-1:0]), .live(live), .aux(aux)
  );

  assign live_mode    = live.mode;
  assign live_port    = live.port;
  assign live_fmt     = live.fmt;
  assign live_div_lo  = div_low(live.div);
  assign live_clk_ctl = clk_ctl_merge(live.div, aux);
  assign tx_break     = live.fmt[BRK_BIT];

  always_comb begin
    unique case (rd_addr)
      A_MODE:   rd_data = shadow.mode;
      A_PORT:   rd_data = shadow.port;
      A_FMT:    rd_data = shadow.fmt;
      A_DIV_LO: rd_data = div_low(shadow.div);
      A_DIV_HI: rd_data = {{(2*DATA_W-DIV_W){1'b0}}, shadow.div[DIV_W-1:DATA_W]};
      A_AUX:    rd_data = live_clk_ctl;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cfg_commit_chk.sv
module cfg_commit_chk
  import cfgc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tx_idle,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [AUX_W-1:0]  aux_data,
  input logic              pending,
  input logic              commit,
  input logic              cfg_wr,
  input cfg_set_t          shadow,
  input logic [DATA_W-1:0] live_mode,
  input logic [DATA_W-1:0] live_port,
  input logic [DATA_W-1:0] live_fmt,
  input logic [DATA_W-1:0] live_div_lo,
  input logic [DATA_W-1:0] live_clk_ctl,
  input logic              tx_break
);
  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_idle |=> $stable(live_mode) && $stable(live_port) && $stable(live_fmt) &&
                 $stable(live_div_lo) && $stable(live_clk_ctl[7:6]));

  // R2
  wr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> pending);

  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && tx_idle && !cfg_wr) |=> !pending);

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live_mode == $past(shadow.mode)) && (live_port == $past(shadow.port)) &&
               (live_fmt == $past(shadow.fmt)) &&
               ({live_clk_ctl[7:6], live_div_lo} == $past(shadow.div)));

  // R5
  aux_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_AUX) |=> $stable(live_clk_ctl[5:0]));

  // R6
  aux_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_AUX) |=> live_clk_ctl[5:0] == $past(aux_data));

  // R7
  brk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_break) |-> $past(commit));

  // R8
  clash_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cfg_wr) |=> pending);
endmodule

bind cfg_shadow_commit cfg_commit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_idle(tx_idle), .wr_en(wr_en), .wr_addr(wr_addr),
  .aux_data(wr_data[5:0]), .pending(pending), .commit(commit), .cfg_wr(cfg_wr),
  .shadow(shadow), .live_mode(live_mode), .live_port(live_port),
  .live_fmt(live_fmt), .live_div_lo(live_div_lo), .live_clk_ctl(live_clk_ctl),
  .tx_break(tx_break)
);

// File: tb/tb_cfg_shadow_commit.sv
`timescale 1ns/1ps
module tb_cfg_shadow_commit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tx_idle = 1'b0;
  logic [7:0] live_mode, live_port, live_fmt, live_div_lo, live_clk_ctl;
  logic       tx_break;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_shadow_commit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_idle(tx_idle),
    .live_mode(live_mode), .live_port(live_port), .live_fmt(live_fmt),
    .live_div_lo(live_div_lo), .live_clk_ctl(live_clk_ctl), .tx_break(tx_break)
  );

  // behavioural reference: plain integers per field
  int s_mode, s_port, s_fmt, s_div;
  int l_mode, l_port, l_fmt, l_div, l_aux;
  bit armed;

  task automatic model_reset();
    s_mode = 'h0C; s_port = 'h16; s_fmt = 'h03; s_div = 23;
    l_mode = s_mode; l_port = s_port; l_fmt = s_fmt; l_div = s_div;
    l_aux = 'h38; armed = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit fire;
      bit hit;
      fire = armed && tx_idle;
      hit = wr_en && (wr_addr < 5);
      if (fire) begin
        l_mode = s_mode; l_port = s_port; l_fmt = s_fmt; l_div = s_div;
      end
      if (wr_en) begin
        case (wr_addr)
          0: s_mode = wr_data;
          1: s_port = wr_data;
          2: s_fmt = wr_data;
          3: s_div = (s_div / 256) * 256 + wr_data;
          4: s_div = (wr_data % 4) * 256 + (s_div % 256);
          5: l_aux = wr_data % 64;
          default: ;
        endcase
      end
      armed = hit || (armed && !fire);
    end
  end

  function automatic int model_rd(input int a);
    case (a)
      0: return s_mode;
      1: return s_port;
      2: return s_fmt;
      3: return s_div % 256;
      4: return s_div / 256;
      5: return (l_div / 256) * 64 + l_aux;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4", "live_mode", live_mode, l_mode);
      chk("R4", "live_port", live_port, l_port);
      chk("R4", "live_fmt", live_fmt, l_fmt);
      chk("R5", "live_div_lo", live_div_lo, l_div % 256);
      chk("R5", "live_clk_ctl", live_clk_ctl, (l_div / 256) * 64 + l_aux);
      chk("R7", "tx_break", tx_break, (l_fmt / 64) % 2);
      chk("R9", "rd_data", rd_data, model_rd(rd_addr));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = a[2:0]; wr_data = d[7:0];
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic idle_cycles(input bit idle, input int n);
    tx_idle = idle;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #2000000;
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle_cycles(0, 2);
    // R1 reset values
    chk("R1", "reset mode", live_mode, 'h0C);
    chk("R1", "reset port", live_port, 'h16);
    chk("R1", "reset clk_ctl", live_clk_ctl, 'h38);
    idle_cycles(1, 4);
    chk("R1", "idle after reset fmt", live_fmt, 'h03);
    chk("R1", "idle after reset div", live_div_lo, 23);

    // R2 deferred writes with line busy
    tx_idle = 0;
    wr(0, 'hA5); wr(1, 'h3C); wr(2, 'h47); wr(3, 'h81); wr(4, 'h02);
    idle_cycles(0, 3);
    chk("R2", "mode held", live_mode, 'h0C);
    chk("R2", "fmt held", live_fmt, 'h03);
    chk("R7", "break held", tx_break, 0);
    rd_addr = 0; #1 chk("R9", "rd mode shadow", rd_data, 'hA5);
    rd_addr = 4; #1 chk("R9", "rd div hi shadow", rd_data, 'h02);
    // R3/R4/R5 commit on idle
    tx_idle = 1;
    @(negedge clk); #1;
    chk("R4", "mode committed", live_mode, 'hA5);
    chk("R4", "port committed", live_port, 'h3C);
    chk("R5", "div lo", live_div_lo, 'h81);
    chk("R5", "clk_ctl merge", live_clk_ctl, 'hB8);
    chk("R7", "break set", tx_break, 1);

    // R6 aux immediate while busy
    tx_idle = 0;
    wr(5, 'hC7);
    chk("R6", "aux immediate", live_clk_ctl, 'hC7 & 'h3F | 'h80);
    rd_addr = 5; #1 chk("R9", "rd aux live", rd_data, 'h87);

    // R3 already idle: one edge after the write edge
    tx_idle = 1;
    @(negedge clk); #1;
    wr(0, 'h5A);
    chk("R3", "not yet", live_mode, 'hA5);
    @(negedge clk); #1;
    chk("R3", "committed next edge", live_mode, 'h5A);

    // R8 write in the commit cycle
    tx_idle = 0;
    wr(1, 'h11);
    tx_idle = 1; wr_en = 1; wr_addr = 1; wr_data = 'h22;
    @(negedge clk); #1;
    wr_en = 0;
    chk("R8", "old value committed", live_port, 'h11);
    @(negedge clk); #1;
    chk("R8", "new value follows", live_port, 'h22);

    // R9 unused addresses
    wr(6, 'hFF); wr(7, 'hEE);
    idle_cycles(1, 2);
    rd_addr = 6; #1 chk("R9", "rd unused", rd_data, 0);
    chk("R9", "unused no effect", live_port, 'h22);

    // R7 break release deferred
    tx_idle = 0;
    wr(2, 'h07);
    chk("R7", "break still on", tx_break, 1);
    idle_cycles(1, 1);
    chk("R7", "break off", tx_break, 0);

    // random mix, model compared every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      wr_en = ($urandom % 3) == 0;
      wr_addr = $urandom % 8;
      wr_data = $urandom % 256;
      rd_addr = $urandom % 8;
      tx_idle = ($urandom % 4) == 0;
    end
    @(negedge clk); #1 wr_en = 0;
    idle_cycles(1, 3);
    finish_run();
  end
endmodule